// File: doc/BRIEF.md
# Runtime-Configurable Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. The line idles high. A frame is a low start bit, then 7 or 8 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. The frame format and the bit period are chosen at run time through configuration inputs. The bit period is given directly as a count of system clocks per bit. The block oversamples the line with the system clock and takes each bit at the middle of its period.

A character that arrives whole is shown on the data output together with a one-cycle ready pulse. A character whose stop bit is low, or whose parity bit is wrong, is thrown away. It raises a one-cycle error pulse on a separate output for each kind of error, and it raises no ready pulse. The data output is only guaranteed while ready is high, so a user that needs to keep the value must register it. A run enable stops the receiver: while it is low the line is ignored and no event is raised.

Top module: `uart_char_rx`

## Requirements
- R1: While reset is held and after reset is released with an idle line, rx_ready, rx_par_err and rx_fmt_err are 0 and rx_byte is 0.
- R2: For a valid frame, rx_byte holds the data bits with the first bit received in bit 0, and rx_ready is high for exactly one cycle. That pulse is visible right after clock edge c0 + 3 + floor(P/2) + (F-1)*P. Here c0 is the edge before which the start bit was driven onto the line, P is cfg_clks_per_bit (at least 4), and F is the number of bits in the frame counting start, data, parity and stop bits. The 3 covers the two-flop synchronizer and the edge detector.
- R3: With cfg_len8=0 the frame carries 7 data bits, and bit 7 of rx_byte reads 0 at the ready pulse.
- R4: With cfg_par_en=1 a parity bit follows the data bits. cfg_par_odd=0 selects even parity, meaning the count of ones in the data and parity bits is even. cfg_par_odd=1 selects odd parity. A frame with a matching parity bit raises rx_ready.
- R5: A parity mismatch with otherwise valid stop bits raises a one-cycle pulse on rx_par_err at the edge that samples the last stop bit. It raises no rx_ready.
- R6: With cfg_par_en=0 there is no parity bit and rx_par_err never rises, whatever the value of cfg_par_odd.
- R7: A stop bit sampled low raises a one-cycle pulse on rx_fmt_err at the edge that samples it, and no rx_ready. With cfg_stop2=1 the second stop bit is checked as well.
- R8: A low level on the line that has ended before the middle of the start bit is dropped without any event, and a following valid frame is received normally.
- R9: While cfg_run is 0 the line is ignored and no event rises. Lowering cfg_run in the middle of a frame abandons that frame.
- R10: Each frame yields at most one of the three events. A format error takes precedence over a parity error. An event lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_run | input | 1 | 1 enables the receiver |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | 1: a parity bit follows the data |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_clks_per_bit | input | 16 | Bit period in system clocks, at least 4 |
| line_in | input | 1 | Serial input, idles high |
| rx_byte | output | 8 | Received character, valid during rx_ready |
| rx_ready | output | 1 | One-cycle pulse: a character was received |
| rx_par_err | output | 1 | One-cycle pulse: parity mismatch, character dropped |
| rx_fmt_err | output | 1 | One-cycle pulse: stop bit low, character dropped |

## Verification
Each event is due on a known cycle. The bench counts it from the edge before which the start bit was put on the line: three cycles for synchronizing and edge detection, then half a bit period to reach the middle of the start bit, then one full period for each later bit up to the one that decides the result. A monitor at the falling clock edge records the number, the kind, the data and the cycle of every event. After each frame the scenario compares that cycle with the figure it worked out itself and checks that no other event appeared. The tests that must produce no event wait out the full frame and then check that all event counts are still zero.

// File: rtl/uart_char_rx_pkg.sv
package uart_char_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_t;

  typedef struct packed {
    logic len8;
    logic par_en;
    logic par_odd;
    logic stop2;
  } rx_fmt_t;

  // XOR of the data bits that are in use for the selected length
  function automatic logic data_parity(input logic [7:0] d, input logic len8);
    logic [7:0] m;
    m = len8 ? d : {1'b0, d[6:0]};
    return ^m;
  endfunction

  // Even parity: data ones plus parity bit even; odd parity: odd
  function automatic logic parity_bad(input logic [7:0] d, input logic len8,
                                      input logic pbit, input logic odd);
    return (data_parity(d, len8) ^ pbit) != odd;
  endfunction

  // Counter load that lands the first sample at the middle of the start bit
  function automatic logic [15:0] half_load(input logic [15:0] period);
    return (period >> 1) - 16'd1;
  endfunction

  function automatic logic [2:0] last_index(input logic len8);
    return len8 ? 3'd7 : 3'd6;
  endfunction

endpackage

// File: rtl/uart_char_rx_sync.sv
module uart_char_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/uart_char_rx_timer.sv
module uart_char_rx_timer
  import uart_char_rx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             active,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] cnt;

  assign tick = active && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      cnt   <= '0;
    end else if (restart) begin
      per_q <= period;
      cnt   <= half_load(period);
    end else if (active) begin
      cnt <= tick ? per_q - 1'b1 : cnt - 1'b1;
    end
  end

  // R2: after a tick the next one is a full period away
  p_tick_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> (cnt == per_q - 1'b1) || !active);
endmodule

// File: rtl/uart_char_rx_frame.sv
module uart_char_rx_frame
  import uart_char_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  rx_fmt_t    fmt_in,
  input  logic       line_s,
  input  logic       bit_tick,
  output logic       restart,
  output logic       active,
  output logic [7:0] data_out,
  output logic       ready,
  output logic       par_err,
  output logic       fmt_err
);
  rx_state_t  state;
  rx_fmt_t    fmt_q;
  logic       line_d;
  logic [2:0] idx;
  logic [7:0] shreg;
  logic       pbit;

  logic start_hit, start_false, in_stop, stop_low, frame_done, par_wrong;

  assign start_hit   = run && (state == ST_IDLE) && line_d && !line_s;
  assign start_false = bit_tick && (state == ST_START) && line_s;
  assign in_stop     = (state == ST_STOP1) || (state == ST_STOP2);
  assign stop_low    = bit_tick && in_stop && !line_s;
  assign frame_done  = bit_tick && line_s &&
                       (((state == ST_STOP1) && !fmt_q.stop2) || (state == ST_STOP2));
  assign par_wrong   = fmt_q.par_en && parity_bad(shreg, fmt_q.len8, pbit, fmt_q.par_odd);
  assign restart     = start_hit;
  assign active      = run && (state != ST_IDLE);
  assign data_out    = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fmt_q   <= '0;
      line_d  <= 1'b1;
      idx     <= '0;
      shreg   <= '0;
      pbit    <= 1'b0;
      ready   <= 1'b0;
      par_err <= 1'b0;
      fmt_err <= 1'b0;
    end else begin
      ready   <= 1'b0;
      par_err <= 1'b0;
      fmt_err <= 1'b0;
      line_d  <= line_s;
      if (!run) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (start_hit) begin
            state <= ST_START;
            fmt_q <= fmt_in;
            shreg <= '0;
            idx   <= '0;
          end
          ST_START: if (bit_tick) state <= start_false ? ST_IDLE : ST_DATA;
          ST_DATA: if (bit_tick) begin
            shreg[idx] <= line_s;
            idx        <= idx + 3'd1;
            if (idx == last_index(fmt_q.len8))
              state <= fmt_q.par_en ? ST_PAR : ST_STOP1;
          end
          ST_PAR: if (bit_tick) begin
            pbit  <= line_s;
            state <= ST_STOP1;
          end
          ST_STOP1, ST_STOP2: if (bit_tick) begin
            if (stop_low) begin
              fmt_err <= 1'b1;
              state   <= ST_IDLE;
            end else if (frame_done) begin
              state <= ST_IDLE;
              if (par_wrong) par_err <= 1'b1;
              else           ready   <= 1'b1;
            end else begin
              state <= ST_STOP2;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R10: never two events together
  p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ready, par_err, fmt_err}));
  // R10: events last one cycle
  p_pulse_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready || par_err || fmt_err) |=> !(ready || par_err || fmt_err));
  // R9: a stopped receiver raises nothing
  p_run_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !(ready || par_err || fmt_err));
  // R6: parity errors only with parity in the captured format
  p_par_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> fmt_q.par_en);
  // R2: results only follow a bit timing tick
  p_ready_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready || fmt_err || par_err) |-> $past(bit_tick));
endmodule

// File: rtl/uart_char_rx.sv
module uart_char_rx
  import uart_char_rx_pkg::*;
#(
  parameter int BAUD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_run,
  input  logic              cfg_len8,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic [BAUD_W-1:0] cfg_clks_per_bit,
  input  logic              line_in,
  output logic [7:0]        rx_byte,
  output logic              rx_ready,
  output logic              rx_par_err,
  output logic              rx_fmt_err
);
  logic    line_s, bit_tick, restart, active;
  rx_fmt_t fmt_in;

  assign fmt_in = '{len8: cfg_len8, par_en: cfg_par_en,
                    par_odd: cfg_par_odd, stop2: cfg_stop2};

  uart_char_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_in(line_in), .d_sync(line_s));

  uart_char_rx_timer #(.CNT_W(BAUD_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .active(active),
    .period(cfg_clks_per_bit), .tick(bit_tick));

  uart_char_rx_frame frame_i (
    .clk(clk), .rst_n(rst_n), .run(cfg_run), .fmt_in(fmt_in),
    .line_s(line_s), .bit_tick(bit_tick), .restart(restart), .active(active),
    .data_out(rx_byte), .ready(rx_ready), .par_err(rx_par_err),
    .fmt_err(rx_fmt_err));

  // R1: no event straight out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !$past(rst_n) |-> !(rx_ready || rx_par_err || rx_fmt_err));
endmodule

// File: tb/uart_char_rx_tb_top.sv
module uart_char_rx_tb_top;
  logic clk = 0, rst_n = 0;
  logic run = 1, len8 = 1, par_en = 0, par_odd = 0, stop2 = 0, line = 1;
  logic [15:0] per = 16;
  logic [7:0] rx_byte;
  logic rx_ready, rx_par_err, rx_fmt_err;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_rdy = 0, n_pe = 0, n_fe = 0, ev_cyc = -1;
  logic [7:0] got_byte = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_char_rx dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_run(run), .cfg_len8(len8),
    .cfg_par_en(par_en), .cfg_par_odd(par_odd), .cfg_stop2(stop2),
    .cfg_clks_per_bit(per), .line_in(line), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .rx_par_err(rx_par_err), .rx_fmt_err(rx_fmt_err));

  always @(negedge clk) if (rst_n) begin
    if (rx_ready)   begin n_rdy++; got_byte = rx_byte; ev_cyc = cyc; end
    if (rx_par_err) begin n_pe++;  ev_cyc = cyc; end
    if (rx_fmt_err) begin n_fe++;  ev_cyc = cyc; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    n_rdy = 0; n_pe = 0; n_fe = 0; ev_cyc = -1;
  endtask

  // pmode: 0 no parity bit, 1 correct parity, 2 wrong parity
  task automatic send(input logic [7:0] d, input int nb, input int pmode,
                      input logic odd, input int nstop, input logic s1,
                      input logic s2, output int c0);
    logic bits[16];
    int n = 0;
    logic p;
    bits[n++] = 1'b0;
    for (int i = 0; i < nb; i++) bits[n++] = d[i];
    p = odd;
    for (int i = 0; i < nb; i++) p = p ^ d[i];
    if (pmode == 2) p = ~p;
    if (pmode != 0) bits[n++] = p;
    bits[n++] = s1;
    if (nstop == 2) bits[n++] = s2;
    @(negedge clk);
    c0 = cyc;
    for (int i = 0; i < n; i++) begin
      line = bits[i];
      repeat (int'(per)) @(negedge clk);
    end
    line = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic int due(input int c0, input int fbits);
    return c0 + 3 + int'(per) / 2 + (fbits - 1) * int'(per);
  endfunction

  task automatic expect_ev(input string tag, input int r, input int pe, input int fe,
                           input int c0, input int fbits);
    chk(n_rdy == r, {tag, " ready count"}, n_rdy, r);
    chk(n_pe == pe, {tag, " par_err count"}, n_pe, pe);
    chk(n_fe == fe, {tag, " fmt_err count"}, n_fe, fe);
    if (r + pe + fe > 0) chk(ev_cyc == due(c0, fbits), {tag, " event cycle"}, ev_cyc, due(c0, fbits));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!rx_ready && !rx_par_err && !rx_fmt_err, "R1 events in reset", rx_ready, 0);
    chk(rx_byte == 0, "R1 byte in reset", rx_byte, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(n_rdy + n_pe + n_fe == 0, "R1 quiet after reset", n_rdy + n_pe + n_fe, 0);
  endtask

  task automatic t_8n1(input logic [7:0] d);
    int c0;
    len8 = 1; par_en = 0; stop2 = 0; clr();
    send(d, 8, 0, 0, 1, 1, 1, c0);
    expect_ev("R2 8N1", 1, 0, 0, c0, 10);
    chk(got_byte == d, "R2 data", got_byte, d);
  endtask

  task automatic t_7bit();
    int c0;
    len8 = 0; par_en = 0; stop2 = 0; clr();
    send(8'hD5, 7, 0, 0, 1, 1, 1, c0);
    expect_ev("R3 7N1", 1, 0, 0, c0, 9);
    chk(got_byte == 8'h55, "R3 7-bit data with bit7 zero", got_byte, 8'h55);
    clr(); par_en = 1; par_odd = 0;
    send(8'h13, 7, 1, 0, 1, 1, 1, c0);
    expect_ev("R3 7E1", 1, 0, 0, c0, 10);
    chk(got_byte == 8'h13, "R3 7E1 data", got_byte, 8'h13);
  endtask

  task automatic t_parity_ok();
    int c0;
    len8 = 1; par_en = 1; par_odd = 0; stop2 = 0; clr();
    send(8'h81, 8, 1, 0, 1, 1, 1, c0);
    expect_ev("R4 8E1", 1, 0, 0, c0, 11);
    chk(got_byte == 8'h81, "R4 8E1 data", got_byte, 8'h81);
    clr(); par_odd = 1; stop2 = 1;
    send(8'h7E, 8, 1, 1, 2, 1, 1, c0);
    expect_ev("R4 8O2", 1, 0, 0, c0, 12);
    chk(got_byte == 8'h7E, "R4 8O2 data", got_byte, 8'h7E);
  endtask

  task automatic t_parity_bad();
    int c0;
    len8 = 1; par_en = 1; stop2 = 0;
    clr(); par_odd = 0;
    send(8'h01, 8, 2, 0, 1, 1, 1, c0);
    expect_ev("R5 even mismatch", 0, 1, 0, c0, 11);
    clr(); par_odd = 1; stop2 = 1;
    send(8'hF0, 8, 2, 1, 2, 1, 1, c0);
    expect_ev("R5 odd mismatch two stops", 0, 1, 0, c0, 12);
  endtask

  task automatic t_par_off();
    int c0;
    len8 = 1; par_en = 0; par_odd = 1; stop2 = 0; clr();
    send(8'h07, 8, 0, 0, 1, 1, 1, c0);
    expect_ev("R6 parity disabled", 1, 0, 0, c0, 10);
    chk(got_byte == 8'h07, "R6 data", got_byte, 8'h07);
  endtask

  task automatic t_stop_bad();
    int c0;
    len8 = 1; par_en = 0; stop2 = 0; clr();
    send(8'h5A, 8, 0, 0, 1, 0, 1, c0);
    expect_ev("R7 stop low", 0, 0, 1, c0, 10);
    repeat (int'(per)) @(negedge clk);
    clr(); stop2 = 1;
    send(8'h5A, 8, 0, 0, 2, 1, 0, c0);
    expect_ev("R7 second stop low", 0, 0, 1, c0, 11);
    repeat (int'(per)) @(negedge clk);
  endtask

  task automatic t_glitch();
    int c0;
    len8 = 1; par_en = 0; stop2 = 0; clr();
    @(negedge clk); line = 0;
    repeat (3) @(negedge clk); line = 1;
    repeat (3 * int'(per)) @(negedge clk);
    chk(n_rdy + n_pe + n_fe == 0, "R8 glitch dropped", n_rdy + n_pe + n_fe, 0);
    send(8'hC3, 8, 0, 0, 1, 1, 1, c0);
    expect_ev("R8 frame after glitch", 1, 0, 0, c0, 10);
    chk(got_byte == 8'hC3, "R8 data", got_byte, 8'hC3);
  endtask

  task automatic t_run_off();
    int c0;
    len8 = 1; par_en = 0; stop2 = 0; clr();
    run = 0;
    send(8'h33, 8, 0, 0, 1, 1, 1, c0);
    chk(n_rdy + n_pe + n_fe == 0, "R9 stopped receiver", n_rdy + n_pe + n_fe, 0);
    run = 1; clr();
    fork
      send(8'h44, 8, 0, 0, 1, 1, 1, c0);
      begin repeat (4 * int'(per)) @(negedge clk); run = 0; end
    join
    chk(n_rdy + n_pe + n_fe == 0, "R9 abandoned mid frame", n_rdy + n_pe + n_fe, 0);
    run = 1; clr();
    send(8'h99, 8, 0, 0, 1, 1, 1, c0);
    expect_ev("R9 after restart", 1, 0, 0, c0, 10);
  endtask

  task automatic t_precedence();
    int c0;
    per = 37; len8 = 1; par_en = 1; par_odd = 0; stop2 = 0; clr();
    send(8'h0F, 8, 2, 0, 1, 0, 1, c0);
    expect_ev("R10 stop and parity bad", 0, 0, 1, c0, 11);
    repeat (int'(per)) @(negedge clk);
    clr();
    send(8'hE2, 8, 1, 0, 1, 1, 1, c0);
    expect_ev("R10 odd period single event", 1, 0, 0, c0, 11);
    chk(got_byte == 8'hE2, "R10 data", got_byte, 8'hE2);
    per = 16;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_8n1(8'hA5);
        t_8n1(8'h3C);
        t_7bit();
        t_parity_ok();
        t_parity_bad();
        t_par_off();
        t_stop_bad();
        t_glitch();
        t_run_off();
        t_precedence();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule